// File: doc/BRIEF.md
# Video Flag Position Classifier

The block watches a thresholded monochrome video stream: a vertical sync, a horizontal sync and a one-bit pixel per clock, where 1 is white. A target carries 130 white flags on a black background, in two rows of 65. Each flag can sit in one of three vertical states. The block sorts every flag into its state while the picture streams past, so it needs no frame buffer.

After each vertical sync the block counts scan lines and the pixels within each line. On a few probe line pairs it measures each flag's fixed column window. The probe pairs are set relative to a per-row line base. Each flag gets a 2-bit code in a result array.

Codes build up in a working copy during the field. The next vertical sync copies them into the readable copy in one step and pulses a one-cycle strobe. Software or a downstream engine then reads any flag through a combinational read port.

Top module: `flag_pos_classifier`

## Requirements
- R1: After reset every readable code is 0, the conflict output is 0 and frame_done is 0.
- R2: The line count becomes 0 on the first clock after vsync falls. It increases by one on each rising edge of hsync. The first pixel clock after an hsync pulse is column 0.
- R3: Flag k of row r (k counted from 0) is measured only over columns COL_OFFr + 2*k*FLAG_W up to that value + FLAG_W - 1. White pixels in the gap columns between flags have no effect on any code.
- R4: On a probe line a flag counts as white when twice the number of 1 pixels in its window is at least FLAG_W. Fewer pixels count as black.
- R5: Relative to the row's line base, lines 5 and 6 give code 1, lines 10 and 11 give code 2, and lines 15 and 16 give code 3. One white line of a pair is enough. Lines outside these pairs have no effect on any code.
- R6: Row 0 uses LINE_BASE0 and COL_OFF0 and fills result slots 0 to FLAGS_PER_ROW-1. Row 1 uses LINE_BASE1 and COL_OFF1 and fills slots FLAGS_PER_ROW to 2*FLAGS_PER_ROW-1.
- R7: A flag that is white on no probe pair in a field reads code 0.
- R8: A flag that is white in more than one band reads the lowest of those codes. The conflict output then reads 1 for that field. A later field without such a flag reads 0.
- R9: On the first clock edge that sees vsync high, all codes and the conflict bit of the field just ended are published. frame_done is high for exactly the following cycle. Published values then stay unchanged until the next publish, and the working copy starts the new field empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Vertical sync, active high |
| hsync | input | 1 | Horizontal sync, active high |
| pix | input | 1 | Thresholded pixel, 1 = white |
| rd_addr | input | ADDR_W | Flag index to read |
| rd_code | output | 2 | Published code of flag rd_addr (0 none, 1..3 state) |
| conflict | output | 1 | Some flag hit more than one band in the published field |
| frame_done | output | 1 | One-cycle strobe when new results are published |

## Verification
The codes and the conflict bit of a field change on the first clock edge that samples vsync high. frame_done is high only for the cycle after that edge. The bench raises vsync at a falling edge and samples frame_done at the next falling edge and again one cycle later. rd_code is combinational from the published array, so the bench sets rd_addr at a falling edge and reads rd_code 1 ns later, after the strobe, while vsync is still held. Expected codes come from the pixel pattern the bench itself drew for the previous field.

// File: rtl/flag_pos_classifier.sv
module flag_pos_classifier #(
  parameter int FLAGS_PER_ROW = 65,
  parameter int FLAG_W        = 8,
  parameter int COL_OFF0      = 16,
  parameter int COL_OFF1      = 24,
  parameter int LINE_BASE0    = 20,
  parameter int LINE_BASE1    = 60,
  parameter int LINE_BITS     = 10,
  parameter int COL_BITS      = 12,
  localparam int NFLAGS = 2 * FLAGS_PER_ROW,
  localparam int ADDR_W = $clog2(NFLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              hsync,
  input  logic              pix,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_code,
  output logic              conflict,
  output logic              frame_done
);
  localparam int PH_W  = $clog2(2 * FLAG_W);
  localparam int K_W   = $clog2(FLAGS_PER_ROW + 1);
  localparam int CNT_W = $clog2(FLAG_W + 1);

  function automatic logic [1:0] band_of(input logic [LINE_BITS-1:0] ln, input int base);
    int d;
    d = int'(ln) - base;
    case (d)
      5, 6:    return 2'd1;
      10, 11:  return 2'd2;
      15, 16:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  logic                 vs_q, hs_q, conf_sh;
  logic [LINE_BITS-1:0] line;
  logic [COL_BITS-1:0]  col;
  logic [PH_W-1:0]      ph;
  logic [K_W-1:0]       k;
  logic [CNT_W-1:0]     cnt;
  logic [1:0]           sh  [NFLAGS];
  logic [1:0]           res [NFLAGS];

  wire [1:0]          b0      = band_of(line, LINE_BASE0);
  wire [1:0]          b1      = band_of(line, LINE_BASE1);
  wire                row     = (b0 == 2'd0);
  wire [1:0]          band    = row ? b1 : b0;
  wire [COL_BITS-1:0] off     = row ? COL_BITS'(COL_OFF1) : COL_BITS'(COL_OFF0);
  wire                probe   = !vsync && !hsync && band != 2'd0;
  wire                running = probe && col >= off && int'(k) < FLAGS_PER_ROW;
  wire                in_win  = int'(ph) < FLAG_W;
  wire                win_end = running && int'(ph) == FLAG_W - 1;
  wire [CNT_W-1:0]    tot     = cnt + CNT_W'(pix);
  wire                white   = 2 * int'(tot) >= FLAG_W;
  wire [ADDR_W-1:0]   idx     = ADDR_W'(k) + (row ? ADDR_W'(FLAGS_PER_ROW) : ADDR_W'(0));
  wire                publish = vsync && !vs_q;

  assign rd_code = (int'(rd_addr) < NFLAGS) ? res[rd_addr] : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q <= 1'b0; hs_q <= 1'b0;
      line <= '1; col <= '0; ph <= '0; k <= '0; cnt <= '0;
      conf_sh <= 1'b0; conflict <= 1'b0; frame_done <= 1'b0;
      for (int i = 0; i < NFLAGS; i++) begin
        sh[i]  <= 2'd0;
        res[i] <= 2'd0;
      end
    end else begin
      vs_q <= vsync;
      hs_q <= hsync;
      frame_done <= 1'b0;
      if (hsync) begin
        col <= '0; ph <= '0; k <= '0; cnt <= '0;
      end else begin
        if (col != '1) col <= col + 1'b1;
        if (running) begin
          if (int'(ph) == 2 * FLAG_W - 1) begin
            ph <= '0;
            k  <= k + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
          if (in_win) cnt <= win_end ? '0 : tot;
        end
      end
      if (vs_q && !vsync) line <= '0;
      else if (hsync && !hs_q && line != '1) line <= line + 1'b1;
      if (publish) begin
        for (int i = 0; i < NFLAGS; i++) begin
          res[i] <= sh[i];
          sh[i]  <= 2'd0;
        end
        conflict   <= conf_sh;
        conf_sh    <= 1'b0;
        frame_done <= 1'b1;
      end else if (win_end && white) begin
        if (sh[idx] == 2'd0) sh[idx] <= band;
        else if (sh[idx] != band) conf_sh <= 1'b1;
      end
    end
  end

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  p_conflict_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(conflict));
  p_codes_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && $stable(rd_addr)) |-> $stable(rd_code));
  p_line_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync) |=> line == '0);
  p_col_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> col == '0);
endmodule

// File: tb/sim_flag_pos_classifier.sv
`timescale 1ns/1ps
module sim_flag_pos_classifier;
  localparam int NPR = 4, FW = 4, OFF0 = 3, OFF1 = 5, LB0 = 0, LB1 = 20;
  localparam int NF = 2 * NPR, LINES = 40, PIXELS = 50;

  logic clk = 0, rst_n = 0, vsync = 0, hsync = 0, pix = 0;
  logic [2:0] rd_addr = '0;
  logic [1:0] rd_code;
  logic conflict, frame_done;

  flag_pos_classifier #(.FLAGS_PER_ROW(NPR), .FLAG_W(FW), .COL_OFF0(OFF0), .COL_OFF1(OFF1),
    .LINE_BASE0(LB0), .LINE_BASE1(LB1), .LINE_BITS(8), .COL_BITS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync), .pix(pix),
    .rd_addr(rd_addr), .rd_code(rd_code), .conflict(conflict), .frame_done(frame_done));

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  int msk [NF];
  int npx [NF];
  int exp_code [NF];
  int exp_conf;
  bit gapfill, noise;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pidx(input int d);
    case (d)
      5: return 0; 6: return 1; 10: return 2; 11: return 3; 15: return 4; 16: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic pix_at(input int l, input int c);
    logic v = 0;
    for (int r = 0; r < 2; r++) begin
      int li, off;
      li  = pidx(l - (r ? LB1 : LB0));
      off = r ? OFF1 : OFF0;
      if (li >= 0 && c >= off) begin
        int rel, k, p;
        rel = c - off; k = rel / (2 * FW); p = rel % (2 * FW);
        if (k < NPR) begin
          if (p < FW) begin
            if (msk[r*NPR+k][li] && p < npx[r*NPR+k]) v = 1;
          end else if (gapfill) v = 1;
        end
      end
    end
    if (noise && pidx(l - LB0) < 0 && pidx(l - LB1) < 0) v = 1;
    return v;
  endfunction

  task automatic gen(input int f);
    exp_conf = 0;
    gapfill = f[0];
    noise   = f[1];
    for (int i = 0; i < NF; i++) begin
      int sel, nb;
      sel = (i * 3 + f * 5) % 8;
      if (f[0] && sel >= 6) sel = sel % 6;
      case (sel)
        0: begin msk[i] = 0;        npx[i] = 4; end
        1: begin msk[i] = 'b000001; npx[i] = 2; end
        2: begin msk[i] = 'b000010; npx[i] = 4; end
        3: begin msk[i] = 'b001100; npx[i] = 3; end
        4: begin msk[i] = 'b100000; npx[i] = 2; end
        5: begin msk[i] = 'b010000; npx[i] = 1; end
        6: begin msk[i] = 'b010001; npx[i] = 4; end
        default: begin msk[i] = 'b101000; npx[i] = 2; end
      endcase
      exp_code[i] = 0;
      nb = 0;
      if (npx[i] * 2 >= FW)
        for (int b = 2; b >= 0; b--)
          if (((msk[i] >> (2 * b)) & 3) != 0) begin
            exp_code[i] = b + 1;
            nb++;
          end
      if (nb > 1) exp_conf = 1;
    end
  endtask

  task automatic publish_and_check(input bit have_exp);
    @(negedge clk) vsync = 1;
    @(negedge clk) check("R9 frame_done pulse", frame_done, 1);
    @(negedge clk) check("R9 frame_done one cycle", frame_done, 0);
    for (int i = 0; i < NF; i++) begin
      rd_addr = 3'(i);
      #1;
      if (have_exp) check($sformatf("R3 R4 R5 R6 R7 code flag %0d", i), rd_code, exp_code[i]);
      else          check($sformatf("R7 R9 empty field flag %0d", i), rd_code, 0);
    end
    check("R8 conflict", conflict, have_exp ? exp_conf : 0);
    @(negedge clk) vsync = 0;
  endtask

  task automatic run_field();
    for (int c = 0; c < 5; c++) begin
      @(negedge clk) pix = pix_at(0, c);
    end
    for (int l = 1; l <= LINES; l++) begin
      @(negedge clk) begin hsync = 1; pix = 0; end
      @(negedge clk);
      for (int c = 0; c < PIXELS; c++) begin
        @(negedge clk) begin hsync = 0; pix = pix_at(l, c); end
      end
    end
    @(negedge clk) pix = 0;
  endtask

  initial begin
    #1000000;
    fails++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 frame_done", frame_done, 0);
    check("R1 conflict", conflict, 0);
    for (int i = 0; i < NF; i++) begin
      rd_addr = 3'(i);
      #1;
      check("R1 code", rd_code, 0);
    end
    publish_and_check(0);
    for (int f = 0; f < 8; f++) begin
      gen(f);
      run_field();
      publish_and_check(1);
    end
    publish_and_check(0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule